// File: doc/BRIEF.md
# SD Card SPI Single-Block Read Engine

This block fetches one 512-byte data block from an SD card that runs in SPI mode. It passes each received data byte to an external receive FIFO through a one-cycle write strobe. The SPI clock is the system clock divided by two, so a 50 MHz system clock gives a 25 MHz SPI clock. A single pulse on `rd_req` starts the whole transaction. The engine lowers chip select, sends the single-block read command with the requested address, and polls for the card's response byte. It then polls for the data start token and clocks in the 512 data bytes with no idle SPI cycles between them. The two trailing CRC bytes are clocked in and dropped. Chip select is then released and the engine pulses either `done` or `err`.

Two 8-bit inputs control the start-token poll, and they set the dead time between consecutive blocks. After each poll byte that does not carry the token, the SPI clock halts for a programmable number of system cycles. A second bound caps how many polls may miss before the read gives up. The intended setting for both bounds is 0xFF. Smaller values shorten the gap between blocks. The host reads blocks back to back by issuing a new request after each completion.

Top module: `sd_spi_block_reader`

## Requirements
- R1: While a transfer is shifting, `spi_sclk` toggles on every system clock (system clock / 2). It idles low, and it is always low while `spi_cs_n` is high. A transaction of N bytes produces exactly 8·N rising edges.
- R2: The command is sent as six bytes: 0x51, the 32-bit `rd_addr` most-significant byte first, then 0xFF. Every other byte sent during the read is 0xFF, and MOSI rests high.
- R3: SPI mode 0. MOSI changes only while the clock is low and never at a rising edge. MISO is sampled on the rising edge. Bytes are shifted most-significant bit first.
- R4: The response is polled for up to 8 bytes. The first byte with bit 7 = 0 is taken as R1. If no such byte arrives within 8 polls, the read ends with `err` and `err_code` = 2'b10.
- R5: An R1 value other than 0x00 ends the read with `err`, `err_code` = 2'b01, and no FIFO writes.
- R6: The start token is 0xFE. After each missed poll the SPI clock stays stopped for `poll_inner_max`+1 system cycles before the next poll. On the (`poll_outer_max`+1)-th miss the read ends at once with `err` and `err_code` = 2'b11.
- R7: A successful read produces exactly 512 `fifo_wr` strobes, one per data byte and in arrival order, each with its byte on `fifo_wdata`. Consecutive strobes are exactly 16 system clocks apart.
- R8: The two CRC bytes after the data are clocked in but never written. `done` rises exactly 16·N + G cycles after the request edge, where N is the number of bytes clocked and G is the sum of the token-poll gaps.
- R9: `spi_cs_n` goes low on the request edge, stays low for the whole transaction, and returns high on the same edge that raises `done` or `err`. A new read can start no earlier than the following cycle, so each pair of blocks is separated by at least one high cycle.
- R10: `rd_req` is ignored while `busy` is high.
- R11: After reset `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=1, and `busy`, `done`, `err` and `fifo_wr` are all 0.
- R12: `done` and `err` are single-cycle pulses and never occur together. `err_code` is nonzero with `err`, reads 0 after a successful read, and holds its value until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the SPI clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | One-cycle read request, taken when idle |
| rd_addr | input | 32 | Block address sent in the command |
| poll_outer_max | input | 8 | Highest allowed missed-token count before timeout |
| poll_inner_max | input | 8 | Gap length minus one, in system cycles, after a missed token poll |
| busy | output | 1 | High from the request edge until completion |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on a failed read |
| err_code | output | 2 | 00 ok, 01 bad R1, 10 R1 timeout, 11 token timeout |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 8 | Data byte for the FIFO |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_mosi | output | 1 | Data to the card |
| spi_miso | input | 1 | Data from the card |

## Verification
The bench drives a card model that varies the response latency, the R1 value and the number of idle bytes before the token. For every read it predicts the exact completion cycle from the byte count and the programmed gaps. A design that stalls the SPI clock between data bytes, or gets the gap length off by one, would complete late and space its FIFO strobes more than 16 cycles apart. The bench also targets several boundaries:
- a token that arrives on the very first poll;
- a token miss count one past the outer bound;
- an R1 response that never arrives;
- a nonzero R1.

Designs that mis-handle these would write CRC bytes into the FIFO, time out one poll early or late, or report the wrong error code. Back-to-back reads and a request raised in the middle of a transfer check that chip select returns high between blocks and that a busy engine does not restart.

// File: rtl/sdrd_pkg.sv
// Shared types and constants for the SD SPI block-read engine.
// Assumes the command set of SD cards in SPI mode (single-block read).
package sdrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RESP,
        ST_TOKEN,
        ST_GAP,
        ST_DATA,
        ST_CRC
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE          = 2'b00,
        ERR_R1_BAD        = 2'b01,
        ERR_R1_TIMEOUT    = 2'b10,
        ERR_TOKEN_TIMEOUT = 2'b11
    } err_code_t;

    localparam logic [7:0] CMD_READ_SINGLE = 8'h51;
    localparam logic [7:0] CMD_CRC_BYTE    = 8'hFF;
    localparam logic [7:0] FILL_BYTE       = 8'hFF;
    localparam logic [7:0] START_TOKEN     = 8'hFE;

endpackage

// File: rtl/sdrd_spi_shifter.sv
// Mode-0 SPI byte shifter clocked at twice the SPI rate.
// Each system clock toggles sclk while a byte is active, so one byte takes
// 16 system clocks. byte_end marks the cycle before the last falling edge;
// a go in that cycle starts the next byte with no idle SPI cycle.
// Assumes go is only raised when idle or together with byte_end.
module sdrd_spi_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_end
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic              active_q;
    logic              sclk_q;
    logic              mosi_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_sr;

    // Last falling edge of the current byte is due at the next clock.
    assign byte_end = active_q && sclk_q && (bit_q == LAST_BIT);

    // Clock generation, MOSI launch on falling edges, MISO capture on rising.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b1;
            bit_q    <= '0;
            tx_sr    <= '1;
            rx_sr    <= '0;
        end else if (go && (!active_q || byte_end)) begin
            active_q <= 1'b1;
            sclk_q   <= 1'b0;
            mosi_q   <= tx_byte[BYTE_W-1];
            tx_sr    <= {tx_byte[BYTE_W-2:0], 1'b1};
            bit_q    <= '0;
        end else if (active_q) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_sr  <= {rx_sr[BYTE_W-2:0], miso};
            end else begin
                sclk_q <= 1'b0;
                if (bit_q == LAST_BIT) begin
                    active_q <= 1'b0;
                    mosi_q   <= 1'b1;
                end else begin
                    mosi_q <= tx_sr[BYTE_W-1];
                    tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b1};
                    bit_q  <= bit_q + 1'b1;
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = mosi_q;
    assign rx_byte = rx_sr;

endmodule

// File: rtl/sdrd_poll_timer.sv
// Two-level wait for the start-token poll.
// The inner counter times the SPI-idle gap after a missed poll; the outer
// counter counts misses. Both are bounded by run-time 8-bit limits.
// Assumes arm is pulsed when the token phase begins.
module sdrd_poll_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             miss,
    input  logic             gap_run,
    input  logic [CNT_W-1:0] outer_max,
    input  logic [CNT_W-1:0] inner_max,
    output logic             gap_over,
    output logic             miss_limit
);
    logic [CNT_W-1:0] inner_q;
    logic [CNT_W-1:0] outer_q;

    assign gap_over   = gap_run && (inner_q == inner_max);
    assign miss_limit = (outer_q == outer_max);

    // Gap timer: counts system cycles while the engine waits between polls.
    always_ff @(posedge clk) begin
        if (!rst_n || arm || gap_over || !gap_run) begin
            inner_q <= '0;
        end else begin
            inner_q <= inner_q + 1'b1;
        end
    end

    // Miss counter: one step per poll byte that lacked the token.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            outer_q <= '0;
        end else if (miss && !miss_limit) begin
            outer_q <= outer_q + 1'b1;
        end
    end

endmodule

// File: rtl/sdrd_sequencer.sv
// Transaction sequencer: command, response poll, token poll with gaps,
// data stream to the FIFO, CRC discard, completion.
// Chooses the next byte in the same cycle as byte_end so the shifter never
// idles inside a phase. Assumes rx_byte is complete whenever byte_end is high.
module sdrd_sequencer
    import sdrd_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int DATA_BYTES    = 512,
    parameter int CRC_BYTES     = 2,
    parameter int R1_POLL_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              byte_end,
    input  logic [7:0]        rx_byte,
    input  logic              gap_over,
    input  logic              miss_limit,
    output logic              go,
    output logic [7:0]        tx_byte,
    output logic              arm,
    output logic              miss,
    output logic              gap_run,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic              fifo_wr,
    output logic [7:0]        fifo_wdata
);
    localparam int CMD_BYTES = ADDR_W / 8 + 2;
    localparam int CMD_W     = ADDR_W + 8;
    localparam int IDX_W     = $clog2(DATA_BYTES + 1);

    seq_state_t         state, nxt;
    logic [IDX_W-1:0]   idx;
    logic [CMD_W-1:0]   cmd_sr;
    logic               cs_n_q, done_q, err_q, fifo_wr_q;
    err_code_t          err_code_q, fin_code;
    logic [7:0]         fifo_data_q;
    logic               fin_ok, fin_err, push;

    // Next-state, shifter launch and completion decisions.
    always_comb begin
        nxt      = state;
        go       = 1'b0;
        tx_byte  = FILL_BYTE;
        fin_ok   = 1'b0;
        fin_err  = 1'b0;
        fin_code = ERR_NONE;
        push     = 1'b0;
        miss     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rd_req) begin
                    go      = 1'b1;
                    tx_byte = CMD_READ_SINGLE;
                    nxt     = ST_CMD;
                end
            end
            ST_CMD: begin
                if (byte_end) begin
                    go = 1'b1;
                    if (idx == IDX_W'(CMD_BYTES - 1)) begin
                        nxt = ST_RESP;
                    end else begin
                        tx_byte = cmd_sr[CMD_W-1 -: 8];
                    end
                end
            end
            ST_RESP: begin
                if (byte_end) begin
                    if (!rx_byte[7]) begin
                        if (rx_byte == 8'h00) begin
                            go  = 1'b1;
                            nxt = ST_TOKEN;
                        end else begin
                            fin_err  = 1'b1;
                            fin_code = ERR_R1_BAD;
                            nxt      = ST_IDLE;
                        end
                    end else if (idx == IDX_W'(R1_POLL_LIMIT - 1)) begin
                        fin_err  = 1'b1;
                        fin_code = ERR_R1_TIMEOUT;
                        nxt      = ST_IDLE;
                    end else begin
                        go = 1'b1;
                    end
                end
            end
            ST_TOKEN: begin
                if (byte_end) begin
                    if (rx_byte == START_TOKEN) begin
                        go  = 1'b1;
                        nxt = ST_DATA;
                    end else begin
                        miss = 1'b1;
                        if (miss_limit) begin
                            fin_err  = 1'b1;
                            fin_code = ERR_TOKEN_TIMEOUT;
                            nxt      = ST_IDLE;
                        end else begin
                            nxt = ST_GAP;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (gap_over) begin
                    go  = 1'b1;
                    nxt = ST_TOKEN;
                end
            end
            ST_DATA: begin
                if (byte_end) begin
                    push = 1'b1;
                    go   = 1'b1;
                    if (idx == IDX_W'(DATA_BYTES - 1)) begin
                        nxt = ST_CRC;
                    end
                end
            end
            ST_CRC: begin
                if (byte_end) begin
                    if (idx == IDX_W'(CRC_BYTES - 1)) begin
                        fin_ok = 1'b1;
                        nxt    = ST_IDLE;
                    end else begin
                        go = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign arm     = (state == ST_RESP) && (nxt == ST_TOKEN);
    assign gap_run = (state == ST_GAP);

    // State, byte index, command holding register and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            idx         <= '0;
            cmd_sr      <= '0;
            cs_n_q      <= 1'b1;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            err_code_q  <= ERR_NONE;
            fifo_wr_q   <= 1'b0;
            fifo_data_q <= '0;
        end else begin
            state     <= nxt;
            done_q    <= fin_ok;
            err_q     <= fin_err;
            fifo_wr_q <= push;
            if (push) begin
                fifo_data_q <= rx_byte;
            end
            if (nxt != state) begin
                idx <= '0;
            end else if (byte_end) begin
                idx <= idx + 1'b1;
            end
            if (state == ST_IDLE && rd_req) begin
                cmd_sr     <= {rd_addr, CMD_CRC_BYTE};
                cs_n_q     <= 1'b0;
                err_code_q <= ERR_NONE;
            end else if (state == ST_CMD && byte_end) begin
                cmd_sr <= cmd_sr << 8;
            end
            if (fin_ok || fin_err) begin
                cs_n_q <= 1'b1;
            end
            if (fin_err) begin
                err_code_q <= fin_code;
            end
        end
    end

    assign cs_n       = cs_n_q;
    assign busy       = (state != ST_IDLE);
    assign done       = done_q;
    assign err        = err_q;
    assign err_code   = err_code_q;
    assign fifo_wr    = fifo_wr_q;
    assign fifo_wdata = fifo_data_q;

endmodule

// File: rtl/sd_spi_block_reader.sv
// Top level of the SD SPI single-block read engine.
// Joins the sequencer, the byte shifter and the token-poll timer.
// Assumes the card is already initialised for SPI mode and that the FIFO
// downstream accepts every strobe.
module sd_spi_block_reader #(
    parameter int ADDR_W        = 32,
    parameter int DATA_BYTES    = 512,
    parameter int CRC_BYTES     = 2,
    parameter int R1_POLL_LIMIT = 8,
    parameter int CNT_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  poll_outer_max,
    input  logic [CNT_W-1:0]  poll_inner_max,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic              fifo_wr,
    output logic [7:0]        fifo_wdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic       go, byte_end, arm, miss, gap_run, gap_over, miss_limit;
    logic [7:0] tx_byte, rx_byte;

    sdrd_sequencer #(
        .ADDR_W        (ADDR_W),
        .DATA_BYTES    (DATA_BYTES),
        .CRC_BYTES     (CRC_BYTES),
        .R1_POLL_LIMIT (R1_POLL_LIMIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .byte_end   (byte_end),
        .rx_byte    (rx_byte),
        .gap_over   (gap_over),
        .miss_limit (miss_limit),
        .go         (go),
        .tx_byte    (tx_byte),
        .arm        (arm),
        .miss       (miss),
        .gap_run    (gap_run),
        .cs_n       (spi_cs_n),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .err_code   (err_code),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata)
    );

    sdrd_spi_shifter #(
        .BYTE_W (8)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .rx_byte  (rx_byte),
        .byte_end (byte_end)
    );

    sdrd_poll_timer #(
        .CNT_W (CNT_W)
    ) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .miss       (miss),
        .gap_run    (gap_run),
        .outer_max  (poll_outer_max),
        .inner_max  (poll_inner_max),
        .gap_over   (gap_over),
        .miss_limit (miss_limit)
    );

endmodule

// File: rtl/sdrd_checker.sv
// Port-level protocol checks for sd_spi_block_reader, attached by bind.
// Assumes the FIFO strobe spacing of one byte time (16 system clocks).
module sdrd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic       spi_mosi,
    input logic       fifo_wr,
    input logic       done,
    input logic       err,
    input logic [1:0] err_code
);
    logic [15:0] gap_cnt;
    logic        seen_wr;

    // Cycles since the previous FIFO strobe within the current transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || spi_cs_n) begin
            gap_cnt <= '0;
            seen_wr <= 1'b0;
        end else if (fifo_wr) begin
            gap_cnt <= '0;
            seen_wr <= 1'b1;
        end else if (!(&gap_cnt)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_mosi_stable_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    assert_fifo_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && seen_wr) |-> (gap_cnt == 16'd15));

    assert_fifo_inside_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !spi_cs_n);

    assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> spi_cs_n);

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 2'b00));

endmodule

bind sd_spi_block_reader sdrd_checker u_sdrd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .fifo_wr  (fifo_wr),
    .done     (done),
    .err      (err),
    .err_code (err_code)
);

// File: tb/test_sd_spi_block_reader.sv
// Bench: behavioural SD card model, FIFO monitor and per-read timing model.
module test_sd_spi_block_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [7:0]  poll_outer_max = 8'hFF;
    logic [7:0]  poll_inner_max = 8'hFF;
    logic        busy, done, err, fifo_wr, spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b1;
    logic [1:0]  err_code;
    logic [7:0]  fifo_wdata;

    always #4 clk = ~clk;

    sd_spi_block_reader i_sd_spi_block_reader (
        .clk (clk), .rst_n (rst_n), .rd_req (rd_req), .rd_addr (rd_addr),
        .poll_outer_max (poll_outer_max), .poll_inner_max (poll_inner_max),
        .busy (busy), .done (done), .err (err), .err_code (err_code),
        .fifo_wr (fifo_wr), .fifo_wdata (fifo_wdata), .spi_sclk (spi_sclk),
        .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi), .spi_miso (spi_miso)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] data_at(input int i, input int seed);
        return 8'((i * 7 + seed) ^ (i >> 2));
    endfunction

    // ---------------- card model ----------------
    int         c_ncr = 0;
    logic [7:0] c_r1 = 8'h00;
    bit         c_r1_never = 0;
    int         c_miss = 0;
    int         c_seed = 0;
    logic [7:0] out_q[$];
    logic [7:0] cur = 8'hFF;
    int         bitpos = 0;
    logic [7:0] rsh = 8'hFF;
    int         rbits = 0;
    int         rbytes = 0;
    logic [7:0] cmd_got[6];
    int         mosi_bad = 0;
    int         rises = 0;

    task automatic build_queue();
        for (int i = 0; i < c_ncr; i++) out_q.push_back(8'hFF);
        if (!c_r1_never) begin
            out_q.push_back(c_r1);
            if (c_r1 == 8'h00) begin
                for (int i = 0; i < c_miss; i++) out_q.push_back(8'hFF);
                out_q.push_back(8'hFE);
                for (int i = 0; i < 512; i++) out_q.push_back(data_at(i, c_seed));
                out_q.push_back(8'hA5);
                out_q.push_back(8'h5A);
            end
        end
    endtask

    always @(negedge spi_cs_n) begin
        rbits = 0; rbytes = 0; out_q.delete(); cur = 8'hFF; bitpos = 0;
        spi_miso = 1'b1; rises = 0; mosi_bad = 0;
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            rises++;
            rsh = {rsh[6:0], spi_mosi};
            rbits++;
            if (rbits == 8) begin
                rbits = 0;
                if (rbytes < 6) cmd_got[rbytes] = rsh;
                else if (rsh != 8'hFF) mosi_bad++;
                rbytes++;
                if (rbytes == 6) build_queue();
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            bitpos++;
            if (bitpos == 8) begin
                bitpos = 0;
                cur = (out_q.size() > 0) ? out_q.pop_front() : 8'hFF;
            end
            spi_miso = cur[7 - bitpos];
        end
    end

    // ---------------- FIFO monitor ----------------
    int f_cnt = 0;
    int f_last = 0;
    always @(negedge clk) begin
        if (fifo_wr === 1'b1) begin
            check(fifo_wdata == data_at(f_cnt, c_seed), "R7 fifo data", fifo_wdata, data_at(f_cnt, c_seed));
            if (f_cnt > 0) check(cyc - f_last == 16, "R7 strobe spacing", cyc - f_last, 16);
            f_last = cyc;
            f_cnt++;
        end
    end

    // ---------------- one read ----------------
    task automatic run_read(input logic [31:0] addr, input int ncr, input logic [7:0] r1,
                            input bit never, input int miss, input int outer, input int inner,
                            input int seed, input bit poke);
        int exp_code, n, g, t0, k, exp_fifo;
        c_ncr = ncr; c_r1 = r1; c_r1_never = never; c_miss = miss; c_seed = seed;
        poll_outer_max = 8'(outer); poll_inner_max = 8'(inner);
        f_cnt = 0;
        if (never) begin exp_code = 2; n = 6 + 8; g = 0; end
        else if (r1 != 0) begin exp_code = 1; n = 6 + ncr + 1; g = 0; end
        else if (miss > outer) begin exp_code = 3; n = 6 + ncr + 1 + outer + 1; g = outer * (inner + 1); end
        else begin exp_code = 0; n = 6 + ncr + 1 + miss + 1 + 512 + 2; g = miss * (inner + 1); end
        exp_fifo = (exp_code == 0) ? 512 : 0;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = addr;
        @(negedge clk);
        rd_req = 1'b0;
        t0 = cyc;
        check(spi_cs_n == 1'b0 && busy == 1'b1, "R9 cs low after request", spi_cs_n, 0);
        k = 0;
        while (!(done || err) && k < 20000) begin
            @(negedge clk);
            k++;
            if (poke && k == 200) begin rd_req = 1'b1; rd_addr = ~addr; end
            else rd_req = 1'b0;
        end
        if (k >= 20000) begin
            check(0, "watchdog read did not finish", k, 16 * n + g);
            return;
        end
        check(cyc - t0 == 16 * n + g, "R8 completion cycle", cyc - t0, 16 * n + g);
        check(done == (exp_code == 0), "R12 done vs err", done, exp_code == 0);
        check(err_code == 2'(exp_code), "R4 R5 R6 error code", err_code, exp_code);
        check(spi_cs_n == 1'b1, "R9 cs released at end", spi_cs_n, 1);
        @(negedge clk);
        check(done == 1'b0 && err == 1'b0, "R12 single-cycle pulse", {done, err}, 0);
        check(err_code == 2'(exp_code), "R12 err_code held", err_code, exp_code);
        check(rises == 8 * n, "R1 sclk rising edges", rises, 8 * n);
        check(cmd_got[0] == 8'h51 && cmd_got[1] == addr[31:24] && cmd_got[2] == addr[23:16] &&
              cmd_got[3] == addr[15:8] && cmd_got[4] == addr[7:0] && cmd_got[5] == 8'hFF,
              "R2 command bytes", {cmd_got[0], cmd_got[1], cmd_got[2]}, {8'h51, addr[31:16]});
        check(mosi_bad == 0, "R2 MOSI fill high", mosi_bad, 0);
        check(f_cnt == exp_fifo, "R7 R8 fifo strobe count", f_cnt, exp_fifo);
        if (poke) begin
            repeat (40) @(negedge clk);
            check(busy == 1'b0 && spi_cs_n == 1'b1, "R10 request while busy ignored", busy, 0);
        end
    endtask

    // ---------------- watchdog ----------------
    always @(negedge clk) begin
        if (cyc > 190000 && !finished) begin
            finished = 1;
            check(0, "watchdog global", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(spi_cs_n == 1 && spi_sclk == 0 && spi_mosi == 1, "R11 SPI pins after reset",
              {spi_cs_n, spi_sclk, spi_mosi}, 3'b101);
        check(busy == 0 && done == 0 && err == 0 && fifo_wr == 0, "R11 status after reset",
              {busy, done, err, fifo_wr}, 0);
        // R6 R7 nominal read with token misses and gaps
        run_read(32'h0001_2345, 1, 8'h00, 0, 3, 10, 4, 11, 0);
        // R6 token on first poll, R4 immediate R1
        run_read(32'hDEAD_BEEF, 0, 8'h00, 0, 0, 0, 0, 22, 0);
        // R6 default bounds, R3 data pattern check
        run_read(32'h8000_0001, 2, 8'h00, 0, 2, 255, 255, 33, 0);
        // R5 nonzero R1
        run_read(32'h0000_0200, 2, 8'h04, 0, 0, 5, 5, 0, 0);
        // R4 R1 never arrives
        run_read(32'h1234_5678, 0, 8'h00, 1, 0, 5, 5, 0, 0);
        // R6 token timeout one past outer bound
        run_read(32'h0F0F_0F0F, 1, 8'h00, 0, 3, 2, 3, 0, 0);
        // R6 misses exactly at outer bound still succeed
        run_read(32'h0000_0400, 0, 8'h00, 0, 2, 2, 1, 44, 0);
        // R10 request during busy; then R9 back-to-back read
        run_read(32'hA5A5_0000, 1, 8'h00, 0, 1, 4, 2, 55, 1);
        run_read(32'hA5A5_0200, 1, 8'h00, 0, 1, 4, 2, 66, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule